// File: doc/BRIEF.md
# Byte FIFO Pair with Watermark Interrupts

This block holds the transmit and receive byte queues of a serial controller, together with the interrupt register set that reports on them. The host writes bytes into the transmit queue and reads bytes from the receive queue. It does this through a single-cycle register strobe interface with word indices. On the engine side, the serial protocol engine pulls transmit bytes and pushes receive bytes over valid/ready byte streams. It also reports four protocol events as one-cycle pulses.

Each queue has a programmable watermark. The transmit watermark fires when the fill level is at or below the threshold. The receive watermark fires when the fill level is at or above it. Each queue also has a flush control. The flush control reads back as set for one cycle and then clears itself, and at that point the queue is empty. Level conditions (empty, full, watermark) follow the queue state continuously. Overrun and protocol events are sticky until they are cleared by a write-one-to-clear access. A mask register selects which raw bits reach the single interrupt line.

Register word indices on `addr`: 0 control, 1 TX data (write), 2 RX data (read), 3 TX threshold, 4 RX threshold, 5 fill levels, 6 mask, 7 raw status, 8 masked status, 9 clear.

Top module: `serfifo_irq_unit`

## Requirements
- R1: After reset both queues are empty and the mask (index 6) reads 0. `irq` is low. The TX threshold (index 3) reads 1 and the RX threshold (index 4) reads 8. The fill levels (index 5, TX count in bits 15:0, RX count in bits 31:16) read 0. The control word reads 0. The raw status (index 7) reads 0x13.
- R2: Bytes written to index 1 leave on `tx_data` in write order. Bytes accepted on the RX stream are returned by reads of index 2 (with `rd_en`) in arrival order.
- R3: Raw bit 0 is set while the TX queue is empty. Raw bit 1 is set while the TX count is at or below the TX threshold. Raw bit 2 is set while the TX count equals DEPTH.
- R4: Raw bit 4 is set while the RX queue is empty. Raw bit 5 is set while the RX count is at or above the RX threshold. Raw bit 6 is set while the RX count equals DEPTH. `rx_ready` is low while the RX queue is full.
- R5: A write to index 1 while the TX queue is full sets raw bit 3 and drops the byte. Raw bit 3 stays set after the queue drains.
- R6: A pulse on `proto_evt[0]`, `[1]`, `[2]` or `[3]` sets raw bit 19, 24, 25 or 28 respectively. The bit stays set until it is cleared.
- R7: Writing index 9 clears each sticky raw bit (3, 19, 24, 25, 28) whose data bit is 1. A write of 0x131F007F clears all of them. Level bits are not affected.
- R8: Masked status (index 8) equals raw AND mask. `irq` is the OR of masked status. Writing 0 to the mask drops `irq` while the raw bits remain set.
- R9: In the control word (index 0), bit 7 flushes the TX queue and bit 8 flushes the RX queue. A set bit reads back as 1 in the cycle after the write. It then reads 0 after the next clock, and the flushed queue is empty.
- R10: A threshold write larger than DEPTH/2-1 stores DEPTH/2-1.
- R11: A read of index 2 with `rd_en` while the RX queue is empty returns 0 and leaves the RX contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (pops RX on index 2) |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, combinational from `addr` |
| tx_data | output | 8 | Head byte of the TX queue |
| tx_valid | output | 1 | TX queue not empty |
| tx_ready | input | 1 | Engine takes the TX head byte |
| rx_data | input | 8 | Byte from the engine |
| rx_valid | input | 1 | Engine offers a byte |
| rx_ready | output | 1 | RX queue can accept a byte |
| proto_evt | input | 4 | Protocol event pulses: done, arbitration lost, bus error, done without stop |
| irq | output | 1 | Combined interrupt line |

## Verification
The queues are tested with short bursts, which separate ordering errors from pointer wrap errors. They are also filled completely to DEPTH, and then one more byte is written. This exposes full detection, overrun stickiness and whether the surplus byte leaks into the stream. Feeding the RX queue one byte below, at, and above the threshold separates the two watermark senses and checks off-by-one errors in the comparison. Flushes issued with data resident, and reads of an empty RX queue, show that pointers reset or stay put as required. Single event pulses under partial masks separate the raw, masked and line paths.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  // register word indices
  localparam logic [3:0] IX_CTRL   = 4'd0;
  localparam logic [3:0] IX_TXDAT  = 4'd1;
  localparam logic [3:0] IX_RXDAT  = 4'd2;
  localparam logic [3:0] IX_TXTHR  = 4'd3;
  localparam logic [3:0] IX_RXTHR  = 4'd4;
  localparam logic [3:0] IX_LEVELS = 4'd5;
  localparam logic [3:0] IX_MASK   = 4'd6;
  localparam logic [3:0] IX_RAW    = 4'd7;
  localparam logic [3:0] IX_MSKD   = 4'd8;
  localparam logic [3:0] IX_CLR    = 4'd9;

  // control bits
  localparam int CB_TXFL = 7;
  localparam int CB_RXFL = 8;

  // event bit positions
  localparam int EB_TX_EMPTY = 0;
  localparam int EB_TX_LOW   = 1;
  localparam int EB_TX_FULL  = 2;
  localparam int EB_TX_OVR   = 3;
  localparam int EB_RX_EMPTY = 4;
  localparam int EB_RX_HIGH  = 5;
  localparam int EB_RX_FULL  = 6;
  localparam int EB_DONE     = 19;
  localparam int EB_ARB      = 24;
  localparam int EB_BERR     = 25;
  localparam int EB_DONE_NS  = 28;

  localparam logic [31:0] STICKY_BITS = 32'h1308_0008;
  localparam logic [31:0] IMPL_BITS   = 32'h1308_007F;

  typedef struct packed {
    logic empty;
    logic full;
    logic mark;
  } sfi_lvl_t;
endpackage

// File: rtl/sfi_rst_sync.sv
module sfi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/sfi_byte_fifo.sv
module sfi_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = AW'(wp_q + 1'b1);
      if (do_pop)  rp_d = AW'(rp_q + 1'b1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  assign dout_o  = mem[rp_q];
  assign count_o = cnt_q;

  // R3 R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0));

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i && !flush_i) |=> (empty_o && $stable(rp_q)));
endmodule

// File: rtl/sfi_irq_bank.sv
module sfi_irq_bank
  import sfi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  level_i,
  input  logic        ovr_set_i,
  input  logic [3:0]  evt_i,
  input  logic        wr_mask_i,
  input  logic        wr_clr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] raw_o,
  output logic [31:0] mask_o,
  output logic [31:0] masked_o,
  output logic        irq_o
);
  logic [31:0] sticky_q, sticky_d, set_vec, clr_vec;
  logic [31:0] mask_q, mask_d;

  always_comb begin
    set_vec = '0;
    set_vec[EB_TX_OVR]  = ovr_set_i;
    set_vec[EB_DONE]    = evt_i[0];
    set_vec[EB_ARB]     = evt_i[1];
    set_vec[EB_BERR]    = evt_i[2];
    set_vec[EB_DONE_NS] = evt_i[3];
    clr_vec  = wr_clr_i ? (wdata_i & STICKY_BITS) : '0;
    sticky_d = ((sticky_q & ~clr_vec) | set_vec) & STICKY_BITS;
    mask_d   = wr_mask_i ? (wdata_i & IMPL_BITS) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      mask_q   <= mask_d;
    end
  end

  assign raw_o    = sticky_q | {25'b0, level_i & 7'h77};
  assign mask_o   = mask_q;
  assign masked_o = raw_o & mask_q;
  assign irq_o    = |masked_o;

  // R6 R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_q & ~clr_vec) != '0) |=>
      ((($past(sticky_q) & ~$past(clr_vec)) & ~sticky_q) == '0));

  // R8
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/serfifo_irq_unit.sv
module serfifo_irq_unit
  import sfi_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int TX_THR_RST = 1,
  parameter int RX_THR_RST = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [3:0]  proto_evt,
  output logic        irq
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int TW     = $clog2(DEPTH);
  localparam int MAXTHR = DEPTH / 2 - 1;
  localparam logic [TW-1:0] TX_RST = TW'((TX_THR_RST > MAXTHR) ? MAXTHR : TX_THR_RST);
  localparam logic [TW-1:0] RX_RST = TW'((RX_THR_RST > MAXTHR) ? MAXTHR : RX_THR_RST);

  logic rst_s_n;
  sfi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  // host decode
  logic wr_ctrl, wr_txd, wr_txthr, wr_rxthr, wr_mask, wr_clr, rd_rxd;
  assign wr_ctrl  = wr_en && (addr == IX_CTRL);
  assign wr_txd   = wr_en && (addr == IX_TXDAT);
  assign wr_txthr = wr_en && (addr == IX_TXTHR);
  assign wr_rxthr = wr_en && (addr == IX_RXTHR);
  assign wr_mask  = wr_en && (addr == IX_MASK);
  assign wr_clr   = wr_en && (addr == IX_CLR);
  assign rd_rxd   = rd_en && (addr == IX_RXDAT);

  function automatic logic [TW-1:0] clamp_thr(input logic [31:0] v);
    return (v > 32'(MAXTHR)) ? TW'(MAXTHR) : v[TW-1:0];
  endfunction

  // control and thresholds
  logic          txfl_q, txfl_d, rxfl_q, rxfl_d;
  logic [TW-1:0] txthr_q, txthr_d, rxthr_q, rxthr_d;

  always_comb begin
    txfl_d  = wr_ctrl && wdata[CB_TXFL];
    rxfl_d  = wr_ctrl && wdata[CB_RXFL];
    txthr_d = wr_txthr ? clamp_thr(wdata) : txthr_q;
    rxthr_d = wr_rxthr ? clamp_thr(wdata) : rxthr_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      txfl_q  <= 1'b0;
      rxfl_q  <= 1'b0;
      txthr_q <= TX_RST;
      rxthr_q <= RX_RST;
    end else begin
      txfl_q  <= txfl_d;
      rxfl_q  <= rxfl_d;
      txthr_q <= txthr_d;
      rxthr_q <= rxthr_d;
    end
  end

  // queues
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_head;
  sfi_lvl_t      tx_lvl, rx_lvl;

  sfi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_s_n), .flush_i(txfl_q),
    .push_i(wr_txd), .din_i(wdata[7:0]),
    .pop_i(tx_ready), .dout_o(tx_data),
    .count_o(tx_cnt), .empty_o(tx_lvl.empty), .full_o(tx_lvl.full));

  sfi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_s_n), .flush_i(rxfl_q),
    .push_i(rx_valid), .din_i(rx_data),
    .pop_i(rd_rxd), .dout_o(rx_head),
    .count_o(rx_cnt), .empty_o(rx_lvl.empty), .full_o(rx_lvl.full));

  assign tx_lvl.mark = (tx_cnt <= {1'b0, txthr_q});
  assign rx_lvl.mark = (rx_cnt >= {1'b0, rxthr_q});
  assign tx_valid    = !tx_lvl.empty;
  assign rx_ready    = !rx_lvl.full;

  // interrupts
  logic [6:0]  lvl_vec;
  logic [31:0] raw, mask, masked;

  always_comb begin
    lvl_vec              = '0;
    lvl_vec[EB_TX_EMPTY] = tx_lvl.empty;
    lvl_vec[EB_TX_LOW]   = tx_lvl.mark;
    lvl_vec[EB_TX_FULL]  = tx_lvl.full;
    lvl_vec[EB_RX_EMPTY] = rx_lvl.empty;
    lvl_vec[EB_RX_HIGH]  = rx_lvl.mark;
    lvl_vec[EB_RX_FULL]  = rx_lvl.full;
  end

  sfi_irq_bank u_irq (
    .clk(clk), .rst_n(rst_s_n), .level_i(lvl_vec),
    .ovr_set_i(wr_txd && tx_lvl.full), .evt_i(proto_evt),
    .wr_mask_i(wr_mask), .wr_clr_i(wr_clr), .wdata_i(wdata),
    .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq));

  // read mux
  always_comb begin
    case (addr)
      IX_CTRL:   rdata = {23'b0, rxfl_q, txfl_q, 7'b0};
      IX_RXDAT:  rdata = {24'b0, rx_lvl.empty ? 8'h00 : rx_head};
      IX_TXTHR:  rdata = 32'(txthr_q);
      IX_RXTHR:  rdata = 32'(rxthr_q);
      IX_LEVELS: rdata = {{(16-CW){1'b0}}, rx_cnt, {(16-CW){1'b0}}, tx_cnt};
      IX_MASK:   rdata = mask;
      IX_RAW:    rdata = raw;
      IX_MSKD:   rdata = masked;
      default:   rdata = '0;
    endcase
  end

  // R9
  txfl_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (txfl_q && !(wr_ctrl && wdata[CB_TXFL])) |=> !txfl_q);

  // R9
  rxfl_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rxfl_q && !(wr_ctrl && wdata[CB_RXFL])) |=> !rxfl_q);

  // R5
  ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_txd && tx_lvl.full) |=> raw[EB_TX_OVR]);

  // R10
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_txthr || wr_rxthr) |=> (txthr_q <= TW'(MAXTHR) && rxthr_q <= TW'(MAXTHR)));
endmodule

// File: tb/tb_serfifo_irq_unit.sv
`timescale 1ns/1ps
module tb_serfifo_irq_unit;
  localparam int DEPTH = 32;
  localparam logic [3:0] A_CTRL = 0, A_TXD = 1, A_RXD = 2, A_TXT = 3, A_RXT = 4,
                         A_LVL = 5, A_MSK = 6, A_RAW = 7, A_MSD = 8, A_CLR = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, tx_ready = 0, rx_valid = 0;
  logic [3:0] addr = 0, proto_evt = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] tx_data, rx_data = 0;
  logic tx_valid, rx_ready, irq;

  int n_vec = 0, n_bad = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  always #2.5 clk = ~clk;

  serfifo_irq_unit #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .proto_evt(proto_evt), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // TX monitor: compares each handshake against the scoreboard (R2)
  always begin
    @(negedge clk);
    #1;
    if (tx_valid && tx_ready) begin
      if (tx_exp.size() == 0) chk("R2 tx unexpected byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 tx order", {24'b0, tx_data}, {24'b0, tx_exp.pop_front()});
    end
  end

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    hr(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tx_put(input logic [7:0] b, input bit expect_taken);
    hw(A_TXD, {24'b0, b});
    if (expect_taken) tx_exp.push_back(b);
  endtask

  task automatic tx_drain(input int n);
    @(negedge clk);
    tx_ready = 1;
    repeat (n) @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic rx_feed(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #1 if (rx_ready) rx_exp.push_back(b);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic rx_pop(input string tag);
    logic [31:0] v;
    hr(A_RXD, v);
    if (rx_exp.size() == 0) chk(tag, v, 32'h0);
    else chk(tag, v, {24'b0, rx_exp.pop_front()});
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    proto_evt[i] = 1'b1;
    @(negedge clk);
    proto_evt = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rchk("R1 raw", A_RAW, 32'h13);
    rchk("R1 mask", A_MSK, 0);
    rchk("R1 txthr", A_TXT, 1);
    rchk("R1 rxthr", A_RXT, 8);
    rchk("R1 levels", A_LVL, 0);
    rchk("R1 ctrl", A_CTRL, 0);

    // R2 short burst, R3 low-water mark
    tx_put(8'hA1, 1); tx_put(8'h5C, 1);
    rchk("R3 two bytes raw", A_RAW, 32'h10);
    tx_put(8'h07, 1);
    rchk("R2 tx level", A_LVL, 3);
    tx_drain(5);
    chk("R2 tx scoreboard empty", tx_exp.size(), 0);
    rchk("R3 empty again raw", A_RAW, 32'h13);

    // R3 full, R5 overrun
    for (int i = 0; i < DEPTH; i++) tx_put(8'(i * 7 + 3), 1);
    rchk("R3 full raw", A_RAW, 32'h14);
    tx_put(8'hEE, 0);
    rchk("R5 overrun raw", A_RAW, 32'h1C);
    rchk("R5 level after overrun", A_LVL, DEPTH);
    tx_drain(DEPTH + 3);
    chk("R5 dropped byte absent", tx_exp.size(), 0);
    chk("R5 tx_valid idle", {31'b0, tx_valid}, 0);
    rchk("R5 overrun sticky", A_RAW, 32'h1B);
    hw(A_CLR, 32'h0000_0008);
    rchk("R7 overrun cleared", A_RAW, 32'h13);

    // R6 protocol events, R7 clear all
    pulse(0);
    rchk("R6 done bit19", A_RAW, 32'h0008_0013);
    pulse(1); pulse(2); pulse(3);
    rchk("R6 all events", A_RAW, 32'h1308_0013);
    hw(A_CLR, 32'h0100_0000);
    rchk("R7 single clear", A_RAW, 32'h1208_0013);
    hw(A_CLR, 32'h131F_007F);
    rchk("R7 clear all keeps levels", A_RAW, 32'h13);

    // R8 mask path
    hw(A_MSK, 32'h0008_0000);
    chk("R8 no irq before event", {31'b0, irq}, 0);
    pulse(0);
    #1 chk("R8 irq raised", {31'b0, irq}, 1);
    rchk("R8 masked", A_MSD, 32'h0008_0000);
    hw(A_MSK, 32'h0);
    #1 chk("R8 mask zero drops irq", {31'b0, irq}, 0);
    rchk("R8 raw kept", A_RAW, 32'h0008_0013);
    hw(A_CLR, 32'h131F_007F);

    // R4 RX watermark and full
    for (int i = 0; i < 7; i++) rx_feed(8'(8'h40 + i));
    rchk("R4 seven below mark", A_RAW, 32'h03);
    rx_feed(8'h47);
    rchk("R4 at mark", A_RAW, 32'h23);
    for (int i = 8; i < DEPTH; i++) rx_feed(8'(8'h40 + i));
    rchk("R4 full raw", A_RAW, 32'h63);
    chk("R4 rx_ready low", {31'b0, rx_ready}, 0);
    rx_feed(8'hFF);
    rchk("R4 level capped", A_LVL, DEPTH << 16);
    for (int i = 0; i < DEPTH; i++) rx_pop("R2 rx order");

    // R11 empty read
    rx_pop("R11 empty read zero");
    rchk("R11 level unchanged", A_LVL, 0);
    rx_feed(8'h9D);
    rx_pop("R11 next byte intact");

    // R9 TX flush
    for (int i = 0; i < 5; i++) tx_put(8'(i), 0);
    hw(A_CTRL, 32'h80);
    addr = A_CTRL;
    #1 chk("R9 tx flush visible", rdata, 32'h80);
    @(negedge clk);
    #1 chk("R9 tx flush self-clear", rdata, 0);
    rchk("R9 tx empty after flush", A_LVL, 0);
    // R9 RX flush
    rx_feed(8'h11); rx_feed(8'h22);
    rx_exp.delete();
    hw(A_CTRL, 32'h100);
    addr = A_CTRL;
    #1 chk("R9 rx flush visible", rdata, 32'h100);
    @(negedge clk);
    #1 chk("R9 rx flush self-clear", rdata, 0);
    rchk("R9 rx empty after flush", A_LVL, 0);

    // R10 clamp
    hw(A_TXT, 100);
    rchk("R10 tx clamp", A_TXT, DEPTH / 2 - 1);
    hw(A_RXT, 32'hFFFF_FFFF);
    rchk("R10 rx clamp", A_RXT, DEPTH / 2 - 1);
    hw(A_RXT, 3);
    rchk("R10 in range kept", A_RXT, 3);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule